// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block sits between a small 8-bit controller core and its external memories. It accepts two kinds of request from the core. The first is an instruction-byte fetch at a 16-bit program address. The second is a data access, either a read or a write, whose address comes from a 16-bit pointer or from an 8-bit indirect register. Each request becomes one complete bus cycle on a shared low address/data byte and a separate high-address byte. The bus cycle uses an address-latch pulse and one of three active-low strobes: program-store read, data read or data write.

Every fetch is routed to either the on-chip program store or the external bus. The route depends on an active-low force-external input and on whether the address lies above the 8 KiB on-chip region. The high-address byte always carries something meaningful. During a bus cycle it carries the upper address, taken from the program counter, the data pointer or the general-purpose port latch, according to the access type. Between cycles it carries the port latch, or, while code runs from external memory, the upper byte of the last fetch address. Each request ends with a one-cycle `done` pulse, and the captured byte appears on `rdata` at the same time.

Top module: `xbus_seq`

## Requirements
- R1: A fetch goes to the external bus when `ext_fetch_n` is 0 or `fetch_pc` is 0x2000 or above. Otherwise it is served internally: `rom_addr` carries `fetch_pc[12:0]` in the first cycle after acceptance, no strobe falls, and `done` rises in the second cycle with `rom_data` on `rdata`.
- R2: An external cycle starts with one cycle in which `ale`=1 and the low address byte is on `ad_out` with `ad_oe`=1. In the next cycle `ale`=0 and the low address is still driven. One turnaround cycle follows, then STROBE_CYCLES cycles (default 2) with the selected strobe low, then one recovery cycle in which `done`=1.
- R3: During an external cycle, `ahi_out` carries `fetch_pc[15:8]` for a fetch and `dat_ptr_hi` for a data access with `dat_wide`=1. For `dat_wide`=0 it carries the port latch value as stored before the acceptance edge.
- R4: Outside a bus cycle, `ahi_out` carries `fetch_pc[15:8]` of the last fetch if that fetch was external, and the port latch otherwise. `hilatch_we` loads `hilatch_wdata` into the latch at the next edge. Bus cycles never alter the stored latch value.
- R5: All strobes are active low and at most one is low at any time. Fetches use `pstb_n`, reads use `rstb_n` and writes use `wstb_n`.
- R6: For reads and external fetches, `ad_oe`=0 from the turnaround cycle through the recovery cycle. `ad_in` is sampled at the edge that ends the last strobe cycle and shown on `rdata` while `done`=1.
- R7: For writes, `dat_wdata` is on `ad_out` with `ad_oe`=1 from the turnaround cycle, one cycle before `wstb_n` falls, through the recovery cycle, one cycle after it rises.
- R8: `bus_idle`=1 only between cycles. A request is accepted at an edge where `bus_idle`=1 and its request line is high. If both requests are high at that edge, the fetch wins and the data request stays pending. `done` is a single-cycle pulse followed by `bus_idle`=1.
- R9: During reset, `ale`=0, all strobes are 1, `ad_oe`=0, `done`=0, `bus_idle`=1 and `ahi_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fetch_n | input | 1 | Forces all fetches external when low |
| fetch_req | input | 1 | Fetch request, held until accepted |
| fetch_pc | input | 16 | Program address of the fetch |
| dat_req | input | 1 | Data access request, held until accepted |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_wide | input | 1 | 1 = 16-bit pointer address, 0 = 8-bit indirect |
| dat_addr_lo | input | 8 | Low address byte of the data access |
| dat_ptr_hi | input | 8 | Pointer high byte, used when `dat_wide`=1 |
| dat_wdata | input | 8 | Write data |
| hilatch_we | input | 1 | Loads the high-port latch |
| hilatch_wdata | input | 8 | New high-port latch value |
| rom_data | input | 8 | Byte returned by the on-chip program store |
| ad_in | input | 8 | Low bus byte as seen on the pins |
| bus_idle | output | 1 | Ready to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read or instruction byte |
| rom_addr | output | 13 | On-chip program store address |
| ale | output | 1 | Address-latch pulse, active high |
| pstb_n | output | 1 | Program-store read strobe |
| rstb_n | output | 1 | Data read strobe |
| wstb_n | output | 1 | Data write strobe |
| ad_out | output | 8 | Low address/data byte driven out |
| ad_oe | output | 1 | Output enable of the low byte |
| ahi_out | output | 8 | High-address / port byte |

## Verification
Two pairs of functions can land on the same clock edge. A fetch request and a data request can both be high while the bus is idle, and a latch write can coincide with the acceptance of an 8-bit indirect access. The bench raises both lines in the same cycle and repeats this in a randomised run. A cycle-accurate behavioural model predicts the result on every cycle: the fetch cycle runs first, the data cycle follows straight after it, and the indirect access carries the old latch byte while the idle port afterwards shows the new one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_SETUP = 3'd3,
        ST_STRB  = 3'd4,
        ST_DONE  = 3'd5,
        ST_IROM  = 3'd6
    } xb_state_e;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_INT   = 2'd3
    } xb_op_e;
endpackage

// File: rtl/xbus_route.sv
// Decides whether a fetch address is served on-chip or on the external bus.
module xbus_route #(
    parameter int PC_W      = 16,
    parameter int ROM_BYTES = 8192
) (
    input  logic            ext_n,
    input  logic [PC_W-1:0] pc,
    output logic            go_ext
);
    localparam logic [PC_W:0] LIMIT = (PC_W+1)'(ROM_BYTES);

    always_comb begin
        go_ext = !ext_n || ({1'b0, pc} >= LIMIT);
    end
endmodule

// File: rtl/xbus_himux.sv
// Source selection for the high address byte, both for a new data
// access and for what the port shows on the pins.
module xbus_himux #(
    parameter int DW = 8
) (
    input  logic          sel_wide,
    input  logic [DW-1:0] ptr_hi,
    input  logic [DW-1:0] latch,
    input  logic          bus_owns,
    input  logic [DW-1:0] bus_hi,
    input  logic          ext_exec,
    input  logic [DW-1:0] last_pc_hi,
    output logic [DW-1:0] data_hi,
    output logic [DW-1:0] pin_hi
);
    always_comb begin
        data_hi = sel_wide ? ptr_hi : latch;
        if (bus_owns) begin
            pin_hi = bus_hi;
        end else if (ext_exec) begin
            pin_hi = last_pc_hi;
        end else begin
            pin_hi = latch;
        end
    end
endmodule

// File: rtl/xbus_pindec.sv
// Decodes the sequencer state flops into bus pin levels.
module xbus_pindec
    import xbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  xb_state_e     st,
    input  xb_op_e        op,
    input  logic [DW-1:0] alo,
    input  logic [DW-1:0] wdat,
    output logic          ale,
    output logic          pstb_n,
    output logic          rstb_n,
    output logic          wstb_n,
    output logic          ad_oe,
    output logic [DW-1:0] ad_out,
    output logic          bus_owns,
    output logic          done,
    output logic          idle
);
    logic addr_phase;
    logic data_phase;
    logic strobing;

    always_comb begin
        addr_phase = (st == ST_ADDR) || (st == ST_HOLD);
        data_phase = (op == OP_WRITE) &&
                     ((st == ST_SETUP) || (st == ST_STRB) || (st == ST_DONE));
        strobing   = (st == ST_STRB);

        ale      = (st == ST_ADDR);
        ad_oe    = addr_phase || data_phase;
        if (addr_phase) begin
            ad_out = alo;
        end else if (data_phase) begin
            ad_out = wdat;
        end else begin
            ad_out = '0;
        end

        pstb_n   = !(strobing && (op == OP_FETCH));
        rstb_n   = !(strobing && (op == OP_READ));
        wstb_n   = !(strobing && (op == OP_WRITE));

        bus_owns = (op != OP_INT) && (st != ST_IDLE) && (st != ST_IROM);
        done     = (st == ST_DONE);
        idle     = (st == ST_IDLE);
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int PC_W          = 16,
    parameter int DW            = 8,
    parameter int ROM_BYTES     = 8192,
    parameter int STROBE_CYCLES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ext_fetch_n,
    input  logic                          fetch_req,
    input  logic [PC_W-1:0]               fetch_pc,
    input  logic                          dat_req,
    input  logic                          dat_we,
    input  logic                          dat_wide,
    input  logic [DW-1:0]                 dat_addr_lo,
    input  logic [DW-1:0]                 dat_ptr_hi,
    input  logic [DW-1:0]                 dat_wdata,
    input  logic                          hilatch_we,
    input  logic [DW-1:0]                 hilatch_wdata,
    input  logic [DW-1:0]                 rom_data,
    input  logic [DW-1:0]                 ad_in,
    output logic                          bus_idle,
    output logic                          done,
    output logic [DW-1:0]                 rdata,
    output logic [$clog2(ROM_BYTES)-1:0]  rom_addr,
    output logic                          ale,
    output logic                          pstb_n,
    output logic                          rstb_n,
    output logic                          wstb_n,
    output logic [DW-1:0]                 ad_out,
    output logic                          ad_oe,
    output logic [DW-1:0]                 ahi_out
);
    localparam int RAW = $clog2(ROM_BYTES);
    localparam int CW  = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYCLES - 1);

    typedef struct packed {
        xb_state_e      st;
        xb_op_e         op;
        logic [CW-1:0]  cnt;
        logic [DW-1:0]  alo;
        logic [DW-1:0]  ahi;
        logic [DW-1:0]  wdat;
        logic [DW-1:0]  rdat;
        logic [DW-1:0]  pc_hi;
        logic [DW-1:0]  latch;
        logic           ext_exec;
        logic [RAW-1:0] rom;
    } seq_t;

    seq_t q, d;

    logic          go_ext;
    logic [DW-1:0] data_hi;
    logic          bus_owns;

    xbus_route #(
        .PC_W      (PC_W),
        .ROM_BYTES (ROM_BYTES)
    ) route_i (
        .ext_n  (ext_fetch_n),
        .pc     (fetch_pc),
        .go_ext (go_ext)
    );

    xbus_himux #(
        .DW (DW)
    ) himux_i (
        .sel_wide   (dat_wide),
        .ptr_hi     (dat_ptr_hi),
        .latch      (q.latch),
        .bus_owns   (bus_owns),
        .bus_hi     (q.ahi),
        .ext_exec   (q.ext_exec),
        .last_pc_hi (q.pc_hi),
        .data_hi    (data_hi),
        .pin_hi     (ahi_out)
    );

    xbus_pindec #(
        .DW (DW)
    ) pindec_i (
        .st       (q.st),
        .op       (q.op),
        .alo      (q.alo),
        .wdat     (q.wdat),
        .ale      (ale),
        .pstb_n   (pstb_n),
        .rstb_n   (rstb_n),
        .wstb_n   (wstb_n),
        .ad_oe    (ad_oe),
        .ad_out   (ad_out),
        .bus_owns (bus_owns),
        .done     (done),
        .idle     (bus_idle)
    );

    always_comb begin
        d = q;
        if (hilatch_we) begin
            d.latch = hilatch_wdata;
        end
        case (q.st)
            ST_IDLE: begin
                if (fetch_req) begin
                    d.ext_exec = go_ext;
                    d.pc_hi    = fetch_pc[PC_W-1:DW];
                    if (go_ext) begin
                        d.st  = ST_ADDR;
                        d.op  = OP_FETCH;
                        d.alo = fetch_pc[DW-1:0];
                        d.ahi = fetch_pc[PC_W-1:DW];
                    end else begin
                        d.st  = ST_IROM;
                        d.op  = OP_INT;
                        d.rom = fetch_pc[RAW-1:0];
                    end
                end else if (dat_req) begin
                    d.st   = ST_ADDR;
                    d.op   = dat_we ? OP_WRITE : OP_READ;
                    d.alo  = dat_addr_lo;
                    d.ahi  = data_hi;
                    d.wdat = dat_wdata;
                end
            end
            ST_ADDR:  d.st = ST_HOLD;
            ST_HOLD:  d.st = ST_SETUP;
            ST_SETUP: begin
                d.st  = ST_STRB;
                d.cnt = '0;
            end
            ST_STRB: begin
                if (q.cnt == CNT_LAST) begin
                    d.st = ST_DONE;
                    if (q.op != OP_WRITE) begin
                        d.rdat = ad_in;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_IROM: begin
                d.rdat = rom_data;
                d.st   = ST_DONE;
            end
            ST_DONE:  d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata    = q.rdat;
    assign rom_addr = q.rom;
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic          pstb_n,
    input logic          rstb_n,
    input logic          wstb_n,
    input logic          ad_oe,
    input logic [DW-1:0] ad_out,
    input logic          done,
    input logic          bus_idle
);
    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!pstb_n, !rstb_n, !wstb_n}) <= 1);

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && ad_oe && $stable(ad_out)));

    assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rstb_n || !pstb_n) |-> (!ad_oe && !ale));

    assert_wr_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wstb_n) |-> (ad_oe && $stable(ad_out)));

    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wstb_n) |-> (ad_oe && $stable(ad_out)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && bus_idle));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> (!ale && pstb_n && rstb_n && wstb_n && !done));
endmodule

bind xbus_seq xbus_seq_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .pstb_n   (pstb_n),
    .rstb_n   (rstb_n),
    .wstb_n   (wstb_n),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .done     (done),
    .bus_idle (bus_idle)
);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
    localparam int NS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_fetch_n = 1'b1;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        dat_req = 1'b0;
    logic        dat_we = 1'b0;
    logic        dat_wide = 1'b0;
    logic [7:0]  dat_addr_lo = '0;
    logic [7:0]  dat_ptr_hi = '0;
    logic [7:0]  dat_wdata = '0;
    logic        hilatch_we = 1'b0;
    logic [7:0]  hilatch_wdata = '0;
    logic [7:0]  rom_data;
    logic [7:0]  ad_in;
    logic        bus_idle, done, ale, pstb_n, rstb_n, wstb_n, ad_oe;
    logic [7:0]  rdata, ad_out, ahi_out;
    logic [12:0] rom_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xbus_seq #(.STROBE_CYCLES(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_fetch_n(ext_fetch_n),
        .fetch_req(fetch_req), .fetch_pc(fetch_pc),
        .dat_req(dat_req), .dat_we(dat_we), .dat_wide(dat_wide),
        .dat_addr_lo(dat_addr_lo), .dat_ptr_hi(dat_ptr_hi), .dat_wdata(dat_wdata),
        .hilatch_we(hilatch_we), .hilatch_wdata(hilatch_wdata),
        .rom_data(rom_data), .ad_in(ad_in),
        .bus_idle(bus_idle), .done(done), .rdata(rdata), .rom_addr(rom_addr),
        .ale(ale), .pstb_n(pstb_n), .rstb_n(rstb_n), .wstb_n(wstb_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ahi_out(ahi_out)
    );

    // ---------------- memory contents as functions ----------------
    function automatic logic [7:0] code_f(input logic [15:0] a);
        return (a[7:0] + 8'h11) ^ a[15:8];
    endfunction
    function automatic logic [7:0] dflt_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
    endfunction
    function automatic logic [7:0] rom_f(input logic [12:0] ra);
        return ra[7:0] ^ {3'b000, ra[12:8]} ^ 8'hC3;
    endfunction

    // ---------------- external memory behaviour ----------------
    logic [7:0] lat_lo = '0;
    logic [7:0] rd_byte = '0;
    logic [7:0] dmem [logic [15:0]];

    assign rom_data = rom_f(rom_addr);
    always @(negedge ale) lat_lo = ad_out;
    always @(negedge rstb_n) begin
        if (dmem.exists({ahi_out, lat_lo})) rd_byte = dmem[{ahi_out, lat_lo}];
        else rd_byte = dflt_f({ahi_out, lat_lo});
    end
    always @(posedge wstb_n) if (rst_n) dmem[{ahi_out, lat_lo}] = ad_out;
    assign ad_in = !pstb_n ? code_f({ahi_out, lat_lo}) : (!rstb_n ? rd_byte : 8'hEE);

    // ---------------- reference model ----------------
    typedef struct {
        bit ale, ps, rs, ws, oe;
        bit [7:0] ado;
        bit hi_idle;
        bit [7:0] ahi;
        bit dn, idl, rdchk;
        bit [7:0] rd;
        bit romchk;
        bit [12:0] rom;
        bit wr, intl;
    } exp_t;

    exp_t q_exp[$];
    exp_t cur;
    bit ext_m = 0;
    bit [7:0] pchi_m = '0;
    bit [7:0] latch_m = '0;
    bit [7:0] mdl_mem [bit [15:0]];

    function automatic exp_t blank();
        exp_t e;
        e = '{default: 0};
        e.ps = 1; e.rs = 1; e.ws = 1; e.hi_idle = 1;
        return e;
    endfunction
    function automatic exp_t idle_e();
        exp_t e;
        e = blank();
        e.idl = 1;
        return e;
    endfunction

    // kind: 0 fetch, 1 read, 2 write
    task automatic push_ext(input int kind, input bit [15:0] a, input bit [7:0] wd);
        exp_t e;
        e = blank();
        e.ale = 1; e.oe = 1; e.ado = a[7:0]; e.hi_idle = 0; e.ahi = a[15:8];
        e.wr = (kind == 2);
        q_exp.push_back(e);
        e.ale = 0;
        q_exp.push_back(e);
        e.oe = e.wr; e.ado = e.wr ? wd : 8'h00;
        q_exp.push_back(e);
        for (int i = 0; i < NS; i++) begin
            exp_t s;
            s = e;
            if (kind == 0) s.ps = 0;
            else if (kind == 1) s.rs = 0;
            else s.ws = 0;
            q_exp.push_back(s);
        end
        e.dn = 1;
        e.rdchk = !e.wr;
        if (kind == 0) e.rd = code_f(a);
        else if (mdl_mem.exists(a)) e.rd = mdl_mem[a];
        else e.rd = dflt_f(a);
        q_exp.push_back(e);
        q_exp.push_back(idle_e());
    endtask

    task automatic push_int(input bit [15:0] pc);
        exp_t e;
        e = blank();
        e.romchk = 1; e.rom = pc[12:0]; e.intl = 1;
        q_exp.push_back(e);
        e = blank();
        e.dn = 1; e.rdchk = 1; e.rd = rom_f(pc[12:0]); e.intl = 1;
        q_exp.push_back(e);
        q_exp.push_back(idle_e());
    endtask

    initial cur = idle_e();

    always @(posedge clk) begin
        if (!rst_n) begin
            q_exp.delete();
            ext_m = 0; pchi_m = '0; latch_m = '0;
            cur = idle_e();
        end else begin
            if (q_exp.size() == 0) begin
                if (fetch_req) begin
                    bit ext;
                    ext = !ext_fetch_n || (fetch_pc >= 16'h2000);
                    ext_m = ext;
                    pchi_m = fetch_pc[15:8];
                    if (ext) push_ext(0, fetch_pc, 8'h00);
                    else push_int(fetch_pc);
                end else if (dat_req) begin
                    bit [15:0] a;
                    a = {dat_wide ? dat_ptr_hi : latch_m, dat_addr_lo};
                    push_ext(dat_we ? 2 : 1, a, dat_wdata);
                    if (dat_we) mdl_mem[a] = dat_wdata;
                end
            end
            if (hilatch_we) latch_m = hilatch_wdata;
            if (q_exp.size() > 0) cur = q_exp.pop_front();
            else cur = idle_e();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            bit [7:0] hexp;
            hexp = cur.hi_idle ? (ext_m ? pchi_m : latch_m) : cur.ahi;
            if (!rst_n) begin
                chk(ale == 0 && pstb_n && rstb_n && wstb_n && !ad_oe && !done && bus_idle,
                    "R9", "reset pins", {ale, pstb_n, rstb_n, wstb_n, ad_oe, done, bus_idle},
                    7'b0111001);
                chk(ahi_out == 8'h00, "R9", "reset ahi_out", ahi_out, 0);
            end else begin
                chk(ale == cur.ale, "R2", "ale", ale, cur.ale);
                chk({pstb_n, rstb_n, wstb_n} == {cur.ps, cur.rs, cur.ws}, "R5", "strobes",
                    {pstb_n, rstb_n, wstb_n}, {cur.ps, cur.rs, cur.ws});
                chk(ad_oe == cur.oe, cur.wr ? "R7" : "R6", "ad_oe", ad_oe, cur.oe);
                if (cur.oe)
                    chk(ad_out == cur.ado, cur.ale ? "R2" : (cur.wr ? "R7" : "R2"), "ad_out",
                        ad_out, cur.ado);
                chk(ahi_out == hexp, cur.hi_idle ? "R4" : "R3", "ahi_out", ahi_out, hexp);
                chk(done == cur.dn && bus_idle == cur.idl, "R8", "done/bus_idle",
                    {done, bus_idle}, {cur.dn, cur.idl});
                if (cur.rdchk)
                    chk(rdata == cur.rd, cur.intl ? "R1" : "R6", "rdata", rdata, cur.rd);
                if (cur.romchk)
                    chk(rom_addr == cur.rom, "R1", "rom_addr", rom_addr, cur.rom);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        while (!bus_idle) @(negedge clk);
    endtask

    task automatic do_fetch(input logic [15:0] pc);
        @(negedge clk);
        fetch_pc = pc; fetch_req = 1;
        wait_idle();
        @(negedge clk);
        fetch_req = 0;
        wait_idle();
    endtask

    task automatic do_data(input bit we, input bit wide, input logic [7:0] lo,
                           input logic [7:0] hi, input logic [7:0] wd);
        @(negedge clk);
        dat_we = we; dat_wide = wide; dat_addr_lo = lo; dat_ptr_hi = hi; dat_wdata = wd;
        dat_req = 1;
        wait_idle();
        @(negedge clk);
        dat_req = 0;
        wait_idle();
    endtask

    task automatic set_latch(input logic [7:0] v);
        @(negedge clk);
        hilatch_wdata = v; hilatch_we = 1;
        @(negedge clk);
        hilatch_we = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        set_latch(8'h3C);                       // R4 idle port shows latch
        repeat (2) @(negedge clk);
        do_fetch(16'h0000);                     // R1 internal
        do_fetch(16'h1FFF);                     // R1 boundary, internal
        do_fetch(16'h2000);                     // R1 boundary, external
        do_fetch(16'hABCD);                     // R3 pc high byte
        repeat (2) @(negedge clk);              // R4 idle holds 0xAB
        ext_fetch_n = 0;
        do_fetch(16'h0042);                     // R1 forced external
        repeat (2) @(negedge clk);
        ext_fetch_n = 1;
        do_fetch(16'h0100);                     // back to internal, idle shows latch (R4)

        do_data(1, 1, 8'h34, 8'h12, 8'h99);     // R7 wide write
        do_data(0, 1, 8'h34, 8'h12, 8'h00);     // R6 read back 0x99
        do_data(1, 0, 8'h55, 8'hF0, 8'h77);     // R3 narrow write uses latch
        do_data(0, 0, 8'h55, 8'hF0, 8'h00);     // R6 read back 0x77
        do_data(0, 1, 8'h10, 8'h80, 8'h00);     // R6 unwritten location

        // R3/R4: latch write in the same cycle as a narrow access acceptance
        @(negedge clk);
        dat_we = 0; dat_wide = 0; dat_addr_lo = 8'h66; dat_req = 1;
        hilatch_wdata = 8'hA5; hilatch_we = 1;
        @(negedge clk);
        dat_req = 0; hilatch_we = 0;
        wait_idle();
        repeat (2) @(negedge clk);

        // R8: fetch and data request in the same cycle
        @(negedge clk);
        fetch_pc = 16'h4321; fetch_req = 1;
        dat_we = 1; dat_wide = 1; dat_addr_lo = 8'h01; dat_ptr_hi = 8'hC0;
        dat_wdata = 8'h5E; dat_req = 1;
        wait_idle();
        @(negedge clk);
        fetch_req = 0;
        wait_idle();
        @(negedge clk);
        dat_req = 0;
        wait_idle();
        do_data(0, 1, 8'h01, 8'hC0, 8'h00);

        // randomised mix, including simultaneous requests
        for (int i = 0; i < 80; i++) begin
            int k;
            k = $urandom_range(0, 5);
            ext_fetch_n = ($urandom_range(0, 3) != 0);
            if (k == 0) do_fetch(16'($urandom));
            else if (k == 1) do_fetch(16'($urandom_range(0, 16'h3FFF)));
            else if (k == 2) set_latch(8'($urandom));
            else if (k == 3) do_data($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                                     8'($urandom_range(0, 7)), 8'($urandom_range(0, 1)),
                                     8'($urandom));
            else begin
                @(negedge clk);
                fetch_pc = 16'($urandom); fetch_req = 1;
                dat_we = ($urandom_range(0, 1) == 1); dat_wide = 1;
                dat_addr_lo = 8'($urandom_range(0, 7)); dat_ptr_hi = 8'h00;
                dat_wdata = 8'($urandom); dat_req = 1;
                hilatch_wdata = 8'($urandom); hilatch_we = ($urandom_range(0, 1) == 1);
                wait_idle();
                @(negedge clk);
                fetch_req = 0; hilatch_we = 0;
                wait_idle();
                @(negedge clk);
                dat_req = 0;
                wait_idle();
            end
        end
        repeat (4) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 60000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule